// File: doc/BRIEF.md
# Divide-and-Conquer Parallel Squarer

This block squares an unsigned operand every clock cycle. The operand is split into an upper half H and a lower half L, and the square is built from three pieces: H squared, L squared and the product H times L. The two half-squares do not overlap in bit position, so they are concatenated into one row. The cross product enters once, shifted by one more bit than the half width, which accounts for the doubling. Its partial-product rows and the concatenated row are compressed by a chain of carry-save rows. A ripple-carry adder then forms the final sum.

The half-squares come from small primitive squarers written as direct logic rather than as AND arrays. By default these are 4-bit primitives. A parameter can instead build each 4-bit half-square from two 2-bit primitives. The operand is registered on entry and the result is registered on exit. A valid flag runs alongside the data, so a host can stream operands back to back or leave gaps.

Top module: `dc_squarer`

## Requirements
- R1: For every value of the 8-bit operand, `out_square` equals the operand multiplied by itself as a 16-bit unsigned number.
- R2: An operand sampled with `in_valid` high at rising edge k produces `out_valid` high and its square on `out_square` after rising edge k+1, and not earlier.
- R3: Operands presented on consecutive cycles produce squares on consecutive cycles, in the same order, with no bubbles.
- R4: `out_valid` is high in a cycle exactly when `in_valid` was high two rising edges earlier, and is low otherwise.
- R5: A cycle with `in_valid` low leaves `out_square` unchanged, whatever value `in_operand` carries in that cycle.
- R6: While `rst_n` is low, `out_valid` and `out_square` are zero. This takes effect at once, without waiting for a clock edge.
- R7: With `BASE_W` = 2, each half-square is built from 2-bit primitives that map 0, 1, 2, 3 to 0, 1, 4, 9. This variant yields the same results as the default `BASE_W` = 4 for every operand.
- R8: Whenever `out_valid` is high, bit 1 of `out_square` is zero and bit 0 equals bit 0 of the operand.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Qualifies `in_operand` in this cycle |
| in_operand | input | OP_W (8) | Unsigned value to square |
| out_valid | output | 1 | `out_square` holds a new square |
| out_square | output | 2*OP_W (16) | Registered square of the operand |

## Verification
The bench builds two copies at the default width of 8 bits: one with `BASE_W` = 4 and one with `BASE_W` = 2. The small width allows an exhaustive sweep of all 256 operands as a back-to-back stream, compared against a bench-side multiply. Both primitive variants are checked on every operand, and both extremes, 0 and 255, are covered. A second stream mixes idle cycles, during which the operand input keeps changing, to test the hold behaviour and the valid pipeline. A reset asserted in the middle of a run checks that the outputs clear at once.

// File: rtl/dcsq_pkg.sv
package dcsq_pkg;

  // Index of the first row of reduction level lvl in the flattened row
  // store, where level l holds (rows - l) rows.
  function automatic int row_base(input int lvl, input int rows);
    return lvl * rows - (lvl * (lvl - 1)) / 2;
  endfunction

  // Total rows across all levels, down to the final pair.
  function automatic int tree_total(input int rows);
    return row_base(rows - 1, rows);
  endfunction

endpackage

// File: rtl/dcsq_prim2.sv
// 2-bit primitive squarer as direct logic: 0,1,2,3 -> 0,1,4,9
module dcsq_prim2 (
  input  logic [1:0] a,
  output logic [3:0] sq
);
  assign sq = {a[1] & a[0], a[1] & ~a[0], 1'b0, a[0]};
endmodule

// File: rtl/dcsq_prim4.sv
// 4-bit primitive squarer. Bit 0 of any square equals the input LSB and
// bit 1 is always zero, so only the upper six bits need logic.
module dcsq_prim4 (
  input  logic [3:0] a,
  output logic [7:0] sq
);
  logic [5:0] upper;

  always_comb begin
    unique case (a)
      4'd0:    upper = 6'd0;
      4'd1:    upper = 6'd0;
      4'd2:    upper = 6'd1;
      4'd3:    upper = 6'd2;
      4'd4:    upper = 6'd4;
      4'd5:    upper = 6'd6;
      4'd6:    upper = 6'd9;
      4'd7:    upper = 6'd12;
      4'd8:    upper = 6'd16;
      4'd9:    upper = 6'd20;
      4'd10:   upper = 6'd25;
      4'd11:   upper = 6'd30;
      4'd12:   upper = 6'd36;
      4'd13:   upper = 6'd42;
      4'd14:   upper = 6'd49;
      default: upper = 6'd56;
    endcase
  end

  assign sq = {upper, 1'b0, a[0]};
endmodule

// File: rtl/dcsq_half.sv
// Half-width squarer; BASE_W picks the primitive used at the leaves.
module dcsq_half #(
  parameter int HW     = 4,
  parameter int BASE_W = 4
) (
  input  logic [HW-1:0]   x,
  output logic [2*HW-1:0] sq
);
  generate
    if (HW == 4 && BASE_W == 4) begin : g_prim4
      dcsq_prim4 u_prim (.a(x), .sq(sq));
    end else if (HW == 4 && BASE_W == 2) begin : g_prim2
      logic [3:0] up_sq;
      logic [3:0] dn_sq;
      logic [3:0] mix;
      dcsq_prim2 u_up (.a(x[3:2]), .sq(up_sq));
      dcsq_prim2 u_dn (.a(x[1:0]), .sq(dn_sq));
      assign mix = {2'b00, x[3:2]} * {2'b00, x[1:0]};
      assign sq  = {up_sq, dn_sq} + {1'b0, mix, 3'b000};
    end else begin : g_generic
      assign sq = {{HW{1'b0}}, x} * {{HW{1'b0}}, x};
    end
  endgenerate
endmodule

// File: rtl/dcsq_csa.sv
// One carry-save row: three addends in, sum and pre-shifted carry out.
module dcsq_csa #(
  parameter int W = 16
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  input  logic [W-1:0] c,
  output logic [W-1:0] sum,
  output logic [W-1:0] carry
);
  assign sum      = a ^ b ^ c;
  assign carry[0] = 1'b0;
  for (genvar i = 0; i < W - 1; i++) begin : g_maj
    assign carry[i+1] = (a[i] & b[i]) | (a[i] & c[i]) | (b[i] & c[i]);
  end
endmodule

// File: rtl/dcsq_rca.sv
// Ripple-carry adder closing the carry-save tree; top carry is dropped.
module dcsq_rca #(
  parameter int W = 16
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  output logic [W-1:0] s
);
  logic [W-1:0] cy;
  assign cy[0] = 1'b0;
  for (genvar i = 0; i < W; i++) begin : g_bit
    assign s[i] = a[i] ^ b[i] ^ cy[i];
    if (i < W - 1) begin : g_cy
      assign cy[i+1] = (a[i] & b[i]) | (a[i] & cy[i]) | (b[i] & cy[i]);
    end
  end
endmodule

// File: rtl/dc_squarer.sv
module dc_squarer
  import dcsq_pkg::*;
#(
  parameter int OP_W   = 8,
  parameter int BASE_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  input  logic [OP_W-1:0]   in_operand,
  output logic              out_valid,
  output logic [2*OP_W-1:0] out_square
);
  localparam int HW    = OP_W / 2;
  localparam int RES_W = 2 * OP_W;
  localparam int ROWS  = HW + 1;
  localparam int NLEV  = ROWS - 2;
  localparam int TOT   = tree_total(ROWS);
  localparam int XSH   = HW + 1;
  localparam int FB    = row_base(NLEV, ROWS);

  logic [OP_W-1:0]  op_q, op_d;
  logic             vld_q;
  logic [RES_W-1:0] sum_w, res_d;
  logic [HW-1:0]    hi, lo;
  logic [2*HW-1:0]  hi_sq, lo_sq;
  logic [RES_W-1:0] stk [TOT];

  // input stage: clock enable on the operand, valid always tracks
  always_comb begin
    op_d = in_valid ? in_operand : op_q;
  end

  always_ff @(posedge clk) begin
    op_q <= op_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) vld_q <= 1'b0;
    else        vld_q <= in_valid;
  end

  // half squares
  assign hi = op_q[OP_W-1:HW];
  assign lo = op_q[HW-1:0];

  dcsq_half #(.HW(HW), .BASE_W(BASE_W)) u_hsq (.x(hi), .sq(hi_sq));
  dcsq_half #(.HW(HW), .BASE_W(BASE_W)) u_lsq (.x(lo), .sq(lo_sq));

  // level 0: concatenated half squares plus the doubled cross-product rows
  assign stk[0] = {hi_sq, lo_sq};
  for (genvar j = 0; j < HW; j++) begin : g_pp
    assign stk[1+j] = {{(RES_W-HW){1'b0}}, hi & {HW{lo[j]}}} << (XSH + j);
  end

  // carry-save reduction: each level turns three rows into two
  for (genvar l = 0; l < NLEV; l++) begin : g_lvl
    localparam int B  = row_base(l, ROWS);
    localparam int NB = row_base(l + 1, ROWS);
    localparam int N  = ROWS - l;
    dcsq_csa #(.W(RES_W)) u_csa (
      .a(stk[B]), .b(stk[B+1]), .c(stk[B+2]),
      .sum(stk[NB]), .carry(stk[NB+1])
    );
    for (genvar j = 3; j < N; j++) begin : g_pass
      assign stk[NB+j-1] = stk[B+j];
    end
  end

  dcsq_rca #(.W(RES_W)) u_rca (.a(stk[FB]), .b(stk[FB+1]), .s(sum_w));

  // output stage
  always_comb begin
    res_d = vld_q ? sum_w : out_square;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid  <= 1'b0;
      out_square <= '0;
    end else begin
      out_valid  <= vld_q;
      out_square <= res_d;
    end
  end
endmodule

// File: rtl/dc_squarer_chk.sv
module dc_squarer_chk #(
  parameter int OP_W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              in_valid,
  input logic [OP_W-1:0]   op_q,
  input logic              vld_q,
  input logic              out_valid,
  input logic [2*OP_W-1:0] out_square
);
  a_r1_square: assert property (@(posedge clk) disable iff (!rst_n)
    vld_q |=> out_square == ({{OP_W{1'b0}}, $past(op_q)} * {{OP_W{1'b0}}, $past(op_q)}));

  a_r2_capture: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> vld_q);

  a_r2_deliver: assert property (@(posedge clk) disable iff (!rst_n)
    vld_q |=> out_valid);

  a_r4_idle: assert property (@(posedge clk) disable iff (!rst_n)
    !vld_q |=> !out_valid);

  a_r5_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !vld_q |=> $stable(out_square));

  a_r8_low_bits: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> (out_square[1] == 1'b0));

  always @(posedge clk) begin
    if (!rst_n) begin
      a_r6_reset: assert (!out_valid && out_square == '0);
    end
  end
endmodule

bind dc_squarer dc_squarer_chk #(.OP_W(OP_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .op_q(op_q),
  .vld_q(vld_q), .out_valid(out_valid), .out_square(out_square)
);

// File: tb/dc_squarer_test.sv
module dc_squarer_test;
  localparam int CLK_HALF = 2;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic [7:0]  in_operand = '0;
  logic        out_valid, out_valid_b2;
  logic [15:0] out_square, out_square_b2;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  logic        p0v, p1v;
  logic [15:0] p0s, p1s, last;

  always #CLK_HALF clk = ~clk;

  dc_squarer #(.OP_W(8), .BASE_W(4)) uut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_operand(in_operand),
    .out_valid(out_valid), .out_square(out_square));

  dc_squarer #(.OP_W(8), .BASE_W(2)) uut_b2 (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_operand(in_operand),
    .out_valid(out_valid_b2), .out_square(out_square_b2));

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic model_clear();
    p0v = 1'b0; p1v = 1'b0; p0s = '0; p1s = '0; last = '0;
  endtask

  // Called at a falling edge: check what the output should show now,
  // then drive the next input and advance one cycle.
  task automatic step(input string sq_tag, input logic v, input logic [7:0] d);
    if (p1v) last = p1s;
    chk("R4 out_valid", out_valid, p1v);
    chk(p1v ? sq_tag : "R5 hold while idle", out_square, last);
    chk("R7 base-2 square", out_square_b2, last);
    chk("R7 base-2 valid", out_valid_b2, p1v);
    if (out_valid) chk("R8 bit1 zero", out_square[1], 0);
    p1v = p0v; p1s = p0s;
    p0v = v;   p0s = {8'd0, d} * {8'd0, d};
    in_valid = v; in_operand = d;
    @(negedge clk);
  endtask

  initial begin
    model_clear();
    repeat (3) @(negedge clk);
    chk("R6 reset valid", out_valid, 0);
    chk("R6 reset square", out_square, 0);
    rst_n = 1'b1;

    // exhaustive back-to-back sweep
    for (int i = 0; i < 256; i++) step("R1/R3 stream square", 1'b1, 8'(i));
    repeat (3) step("R1 drain", 1'b0, 8'hA5);

    // single operand latency
    step("R2 lone square", 1'b1, 8'd200);
    chk("R2 not before second edge", out_valid, 0);
    step("R2 lone square", 1'b0, 8'd17);
    chk("R2 valid one clock after capture", out_valid, 1);
    chk("R2 square one clock after capture", out_square, 40000);
    repeat (2) step("R2 drain", 1'b0, 8'd3);

    // gapped stream, operand keeps moving while idle
    for (int i = 0; i < 300; i++)
      step("R1 gapped square", (i % 3) != 0, 8'((i * 37 + 11) % 256));
    repeat (3) step("R1 drain", 1'b0, 8'h5A);

    // reset in the middle of a stream
    for (int i = 0; i < 4; i++) step("R1 pre-reset", 1'b1, 8'(250 + i));
    rst_n = 1'b0;
    #1;
    chk("R6 async clear valid", out_valid, 0);
    chk("R6 async clear square", out_square, 0);
    in_valid = 1'b0;
    @(negedge clk);
    @(negedge clk);
    chk("R6 held valid", out_valid, 0);
    chk("R6 held square", out_square, 0);
    rst_n = 1'b1;
    model_clear();
    for (int i = 0; i < 8; i++) step("R1 post-reset", 1'b1, 8'(255 - i * 31));
    repeat (3) step("R1 drain", 1'b0, 8'd0);

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL R3 watchdog actual 0 expected 1");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule